// File: doc/BRIEF.md
# SPI Slave Transmitter with Holding Register

This block is the slave end of a four-wire serial link. An external master drives the serial clock, the master-out data line and an active-low select. The block answers on the slave-out line and collects the master's byte. The system side loads outgoing bytes into a holding register that sits in front of the shift register. A byte can therefore be queued while the current transfer is still running, so back-to-back transfers need no exact write timing. Both clock phase modes and both clock polarities are supported. The mode is chosen by two static inputs that change only while select is high.

The serial clock, master-out data and select are passed through a synchronizer into the system clock domain, and clock edges are detected there. Once a transfer has started, the shift register is locked and a write goes into the holding register. The shift register takes the queued byte when the link is idle, which includes the point just after a transfer ends. If no new byte has been queued, the shift register keeps its value and sends it again on the next transfer.

Top module: `spi_slave_dbuf_tx`

## Requirements
- R1: After reset, tx_empty_o is 1, miso_oe_o is 0, miso_o is 0 and the shift register holds 0x00.
- R2: miso_oe_o is 1 only while the synchronized select is low. While select is high, miso_o is 0. A transfer can only be running while select was low in the previous cycle.
- R3: Clock phase 0 (cpha_i=0): the falling of select starts a transfer, and miso_o shows bit 7 at once. The next lower bit appears after each trailing clock edge, and master-out data is captured on each leading clock edge. A leading edge goes from the idle level cpol_i to the opposite level; a trailing edge goes back to cpol_i.
- R4: Clock phase 1 (cpha_i=1): the first leading edge while selected and idle starts a transfer, and miso_o shows bit 7 after that edge. The next lower bit appears after each later leading edge, and master-out data is captured on trailing edges. Select may stay low across consecutive transfers.
- R5: A byte written while no transfer runs moves into the shift register within two clock cycles, and tx_empty_o returns to 1.
- R6: A byte written while a transfer runs stays in the holding register with tx_empty_o at 0, and the shift register does not change. The byte is sent in full by the next transfer.
- R7: When no byte has been written since the last transfer, the next transfer sends the same byte again.
- R8: Bits travel most significant first, eight per transfer. A single-cycle rx_valid_o pulse follows the eighth capture edge, and rx_data_o then holds the master's byte.
- R9: Select rising before the eighth capture edge ends the transfer with no rx_valid_o pulse. The next transfer starts again from bit 7 of the unchanged shift register.
- R10: The cycle after any write, tx_empty_o is 0. A second write before the holding register empties replaces the byte waiting there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase mode |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Master-out data (asynchronous) |
| ss_n_i | input | 1 | Active-low select (asynchronous) |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to queue |
| tx_empty_o | output | 1 | Holding register can take a byte |
| miso_o | output | 1 | Slave-out data |
| miso_oe_o | output | 1 | Output enable for the slave-out line |
| rx_data_o | output | DATA_W | Last byte captured from the master |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is new |

## Verification
The hardest case to reach from the ports is a write that lands while a transfer is in progress. A correct design must hold that byte back while the shift register stays locked, and then hand it over just after the last capture edge. To reach this, the bench forks its serial master, which runs the transfer, against a writer that strikes partway through. A second run of this kind writes twice in mid-transfer to show that the later byte replaces the earlier one. A transfer cut short by select also runs, to show that the following transfer restarts from the top bit.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

   typedef struct packed {
      logic lead;
      logic trail;
   } sck_edge_t;

   localparam logic [2:0] SYNC_RST = 3'b100;

endpackage

// File: rtl/sstx_sync.sv
module sstx_sync #(
   parameter int          STAGES  = 2,
   parameter int          WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d_i};
   end

   assign q_o = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sstx_edge.sv
module sstx_edge
   import sstx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sck_s,
   input  logic      cpol,
   input  logic      sel_s,
   output sck_edge_t edge_o
);
   logic sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   always_comb begin
      edge_o.lead  = sel_s && (sck_s ^ sck_d) && (sck_s != cpol);
      edge_o.trail = sel_s && (sck_s ^ sck_d) && (sck_s == cpol);
   end
endmodule

// File: rtl/sstx_core.sv
module sstx_core
   import sstx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              sel_s,
   input  sck_edge_t         edge_i,
   input  logic              mosi_s,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_empty,
   output logic              miso,
   output logic              busy_o,
   output logic [DATA_W-1:0] shreg_o,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [IDX_W-1:0] TOP_BIT  = IDX_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SMP = CNT_W'(DATA_W - 1);

   logic              busy, sel_q, hold_full;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  smp_cnt;
   logic [DATA_W-1:0] hold, shreg, rx_sh;
   logic              drive_edge, sample_edge, start, last_smp, load;

   // phase 0 drives on trailing edges, phase 1 on leading edges
   assign drive_edge  = cpha ? edge_i.lead  : edge_i.trail;
   assign sample_edge = cpha ? edge_i.trail : edge_i.lead;
   assign start       = !busy && (cpha ? (edge_i.lead && sel_s) : (sel_s && !sel_q));
   assign last_smp    = busy && sample_edge && (smp_cnt == LAST_SMP);
   assign load        = !busy && hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_s;
   end

   // transfer framing and bit pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         smp_cnt <= '0;
         rx_sh   <= '0;
      end else if (!sel_s) begin
         busy    <= 1'b0;
         idx     <= '0;
         smp_cnt <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         idx     <= '0;
         smp_cnt <= '0;
      end else if (busy) begin
         if (drive_edge) idx <= idx + 1'b1;
         if (sample_edge) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            smp_cnt <= smp_cnt + 1'b1;
         end
         if (last_smp) begin
            busy    <= 1'b0;
            idx     <= '0;
            smp_cnt <= '0;
         end
      end
   end

   // holding register and locked shift register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         shreg     <= '0;
      end else begin
         if (load) shreg <= hold;
         if (wr_en) begin
            hold      <= wr_data;
            hold_full <= 1'b1;
         end else if (load) begin
            hold_full <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= last_smp;
         if (last_smp) rx_data <= {rx_sh[DATA_W-2:0], mosi_s};
      end
   end

   assign miso     = shreg[TOP_BIT - idx];
   assign tx_empty = !hold_full;
   assign busy_o   = busy;
   assign shreg_o  = shreg;
endmodule

// File: rtl/spi_slave_dbuf_tx.sv
module spi_slave_dbuf_tx
   import sstx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit RX_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              ss_n_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              tx_empty_o,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              sel_s, core_miso, core_busy, core_rx_done;
   logic [DATA_W-1:0] core_shreg, core_rx;
   sck_edge_t         sck_edge;

   sstx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ss_n_i, mosi_i, sck_i}),
      .q_o   (pins_s)
   );

   assign sel_s = !pins_s[2];

   sstx_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_s  (pins_s[0]),
      .cpol   (cpol_i),
      .sel_s  (sel_s),
      .edge_o (sck_edge)
   );

   sstx_core #(.DATA_W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpha     (cpha_i),
      .sel_s    (sel_s),
      .edge_i   (sck_edge),
      .mosi_s   (pins_s[1]),
      .wr_en    (wr_en_i),
      .wr_data  (wr_data_i),
      .tx_empty (tx_empty_o),
      .miso     (core_miso),
      .busy_o   (core_busy),
      .shreg_o  (core_shreg),
      .rx_data  (core_rx),
      .rx_done  (core_rx_done)
   );

   assign miso_oe_o = sel_s;
   assign miso_o    = sel_s & core_miso;

   if (RX_EN) begin : g_rx
      assign rx_data_o  = core_rx;
      assign rx_valid_o = core_rx_done;
   end else begin : g_no_rx
      assign rx_data_o  = '0;
      assign rx_valid_o = 1'b0;
   end
endmodule

// File: rtl/sstx_chk.sv
module sstx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic              tx_empty_o,
   input logic              miso_oe_o,
   input logic              rx_valid_o,
   input logic              core_busy,
   input logic [DATA_W-1:0] core_shreg
);
   p_busy_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_busy |-> $past(miso_oe_o));

   p_shift_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_busy && $past(core_busy)) |-> $stable(core_shreg));

   p_empty_rise_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty_o) |-> !$past(core_busy));

   p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en_i) |-> !tx_empty_o);

   p_rx_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);
endmodule

bind spi_slave_dbuf_tx sstx_chk #(.DATA_W(DATA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en_i    (wr_en_i),
   .tx_empty_o (tx_empty_o),
   .miso_oe_o  (miso_oe_o),
   .rx_valid_o (rx_valid_o),
   .core_busy  (core_busy),
   .core_shreg (core_shreg)
);

// File: tb/test_spi_slave_dbuf_tx.sv
`timescale 1ns/1ps
module test_spi_slave_dbuf_tx;
   localparam int H = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpol = 1'b0, cpha = 1'b0;
   logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tx_empty, miso, miso_oe, rx_valid;
   logic [7:0] rx_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [7:0] rx_q[$];

   always #2.5 clk = ~clk;

   spi_slave_dbuf_tx i_spi_slave_dbuf_tx (
      .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .cpha_i(cpha),
      .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
      .wr_en_i(wr_en), .wr_data_i(wr_data),
      .tx_empty_o(tx_empty), .miso_o(miso), .miso_oe_o(miso_oe),
      .rx_data_o(rx_data), .rx_valid_o(rx_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // serial master: drives one byte, captures and checks the slave's byte
   task automatic xfer(input logic [7:0] mo, input logic [7:0] exp, input bit keep_sel);
      logic [7:0] got;
      string tag;
      tag = cpha ? "R4" : "R3";
      rx_q.push_back(mo);
      if (!cpha) begin
         mosi = mo[7]; ss_n = 1'b0; #H;
         chk(miso_oe == 1'b1, "R2", 8'(miso_oe), 8'h1);
         for (int i = 7; i >= 0; i--) begin
            got[i] = miso;
            sck = ~cpol; #H;
            sck = cpol;
            if (i > 0) mosi = mo[i-1];
            #H;
         end
      end else begin
         ss_n = 1'b0; #H;
         for (int i = 7; i >= 0; i--) begin
            sck = ~cpol; mosi = mo[i]; #H;
            got[i] = miso;
            sck = cpol; #H;
         end
      end
      chk(got == exp, tag, got, exp);
      if (!keep_sel) begin
         ss_n = 1'b1; #H;
      end
   endtask

   // monitor: compares every received byte against the scoreboard (R8)
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (rx_q.size() == 0) chk(1'b0, "R8 unexpected rx", rx_data, 8'h00);
         else begin
            logic [7:0] e;
            e = rx_q.pop_front();
            chk(rx_data == e, "R8", rx_data, e);
         end
      end
   end

   initial begin
      #(500_000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_empty == 1'b1, "R1 empty", 8'(tx_empty), 8'h1);
      chk(miso_oe == 1'b0, "R1 oe", 8'(miso_oe), 8'h0);
      chk(miso == 1'b0, "R1 miso", 8'(miso), 8'h0);

      // R5: idle write lands in the shift register quickly
      write_byte(8'hA5);
      repeat (2) @(negedge clk);
      chk(tx_empty == 1'b1, "R5", 8'(tx_empty), 8'h1);

      // R3 mode 0, then R7 resend
      xfer(8'h3C, 8'hA5, 1'b0);
      chk(miso_oe == 1'b0 && miso == 1'b0, "R2 idle", {miso_oe, miso}, 8'h0);
      xfer(8'hC3, 8'hA5, 1'b0);   // R7: nothing new queued

      // R3 with idle-high clock
      cpol = 1'b1; sck = 1'b1; #H;
      write_byte(8'h5A);
      xfer(8'h0F, 8'h5A, 1'b0);

      // R4 / R6: phase 1, mid-transfer write, back-to-back with select held
      cpol = 1'b0; cpha = 1'b1; sck = 1'b0; #H;
      write_byte(8'h81);
      fork
         xfer(8'h96, 8'h81, 1'b1);
         begin
            #(3*H);
            write_byte(8'h7E);
            #H;
            chk(tx_empty == 1'b0, "R6 held", 8'(tx_empty), 8'h0);
         end
      join
      xfer(8'h69, 8'h7E, 1'b0);   // R6: deferred byte sent next

      // R4 with idle-high clock
      cpol = 1'b1; sck = 1'b1; #H;
      write_byte(8'hE7);
      xfer(8'h00, 8'hE7, 1'b0);

      // R10: two writes during a transfer, the later one wins
      cpol = 1'b0; cpha = 1'b0; sck = 1'b0; #H;
      fork
         xfer(8'hFF, 8'hE7, 1'b0);
         begin
            #(4*H);
            write_byte(8'h11);
            chk(tx_empty == 1'b0, "R10 first", 8'(tx_empty), 8'h0);
            write_byte(8'h22);
         end
      join
      xfer(8'h44, 8'h22, 1'b0);

      // R9: abort after three bits, then a full transfer from bit 7
      mosi = 1'b0; ss_n = 1'b0; #H;
      for (int i = 0; i < 3; i++) begin
         sck = 1'b1; #H; sck = 1'b0; #H;
      end
      ss_n = 1'b1; #(2*H);
      chk(rx_q.size() == 0, "R9 no rx", 8'(rx_q.size()), 8'h0);
      xfer(8'h5A, 8'h22, 1'b0);

      #(2*H);
      chk(rx_q.size() == 0, "R8 drained", 8'(rx_q.size()), 8'h0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule